// File: doc/BRIEF.md
# Configurable Link LED Controller

This block drives a small bank of status LEDs for an Ethernet port from the port's link state and traffic events. Each LED has a pair of 8-bit configuration registers. These registers choose which link or device condition lights it steadily, which condition makes it blink fast and which makes it blink slow. They also choose which traffic events blank it briefly. Two shared registers set the two blink rates. They also set two whole-bank overrides: a complex blink that flashes every LED together, and a scan that walks a single lit LED across the bank.

Configuration goes through a plain parallel register port with one write strobe and an address. The read data follows the address combinationally. A tick from an external prescaler is the only timebase. A shared divider turns it into a set of phase bits, so every LED set to the same rate blinks in step. The activity blanking is counted in ticks, so that a short frame still gives a visible blink.

Top module: `led_ind_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the registers read back as follows: address 0 (rates) 0xC5, address 1 (overrides) 0x67, and per LED pair (high, low) LED0 0x70/0x03, LED1 0x20/0x00, LED2 0x40/0x00, LED3 0x40/0x20.
- R2: A write at a rising edge stores the data at its address, and that value is read back from then on. The map is: 0 rates, 1 overrides, 2+2i LED i high, 3+2i LED i low. Writes to addresses at or beyond 2+2*NUM_LEDS change nothing, and reads there return 0.
- R3: Bits 7:4 of an LED's high register hold its steady-on condition. The condition codes are: 0 never; 1 link up at 10; 2 at 100; 3 at 10 or 100; 4 at 1000; 5 at 10 or 1000; 6 at 100 or 1000; 7 link up at any of the three speeds; 8 power-down; 9 energy-efficient idle; 0xA autoneg running; 0xB self-test running; 0xC cable diagnostics running; 0xD to 0xF never. The link speed input is coded 0 = 10, 1 = 100, 2 = 1000, and 3 matches no speed.
- R4: When the condition in bits 3:0 of the high register holds, the LED follows the fast blink phase. This takes priority over slow blink and steady-on.
- R5: When the condition in bits 7:4 of the low register holds and the fast condition does not, the LED follows the slow blink phase. This takes priority over steady-on.
- R6: The fast rate sits in bits 7:6 of register 0 and the slow rate in bits 5:4; codes 0..3 mean 2, 4, 8 and 16 Hz. A phase counter advances once every TICK_DIV ticks. Rate code c follows bit 3-c of that counter, so at code 3 the LED changes level every TICK_DIV ticks, and at code 0 every 8*TICK_DIV ticks.
- R7: Bits 2:0 of the low register mask the events TX (bit 0), RX (bit 1) and collision (bit 2); bit 3 has no effect. A masked event in a cycle holds the LED off from the next edge for STRETCH_TICKS ticks, counted after the event, and a further event restarts that count. This outranks all other per-LED sources.
- R8: When the complex blink condition in bits 2:0 of register 1 holds, every LED follows the slow blink phase, regardless of its own settings.
- R9: When the scan condition in bits 6:4 of register 1 holds, exactly one LED is lit: the one whose index equals the low bits of the phase counter. This outranks complex blink.
- R10: The 3-bit codes for the scan and complex blink conditions are 0 never, 1 link up, 2 power-down, 3 energy-efficient idle, 4 autoneg running, 5 self-test running, 6 cable diagnostics running, 7 test mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle strobe from the prescaler |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register address |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for cfg_addr |
| link_up | input | 1 | Link is up |
| link_speed | input | 2 | 0 = 10, 1 = 100, 2 = 1000 Mbit/s |
| pwr_down | input | 1 | Device powered down |
| eee_active | input | 1 | Energy-efficient idle active |
| aneg_busy | input | 1 | Auto-negotiation running |
| selftest_busy | input | 1 | Analog self-test running |
| cdiag_busy | input | 1 | Cable diagnostics running |
| test_mode | input | 1 | Test mode running |
| tx_act | input | 1 | Transmit activity strobe |
| rx_act | input | 1 | Receive activity strobe |
| col_evt | input | 1 | Collision strobe |
| led | output | NUM_LEDS | LED drive, 1 = lit |

## Verification
The LED outputs and the read data are combinational. A change on the level status inputs shows on the LEDs in the same cycle. A register write, a tick or an activity strobe takes effect at the next rising edge and is visible just after it. The bench changes inputs shortly after a rising edge and compares the outputs at the falling edge against a reference model. The model is advanced only after each rising edge, using the inputs that edge sampled. The directed cases wait out the exact number of ticks a requirement names: TICK_DIV ticks per fast toggle, and STRETCH_TICKS ticks of blanking.

// File: rtl/led_ind_pkg.sv
// Shared types and decode functions for the link LED controller.
// Assumes link speed coding 0=10, 1=100, 2=1000, 3=none.
package led_ind_pkg;

    // Snapshot of the status inputs used by the condition decoders.
    typedef struct packed {
        logic up;
        logic s10;
        logic s100;
        logic s1000;
        logic pdown;
        logic eee;
        logic aneg;
        logic selftest;
        logic cdiag;
        logic test;
    } link_state_t;

    // Per-LED configuration fields, unpacked from the two registers.
    typedef struct packed {
        logic [3:0] on_sel;
        logic [3:0] fast_sel;
        logic [3:0] slow_sel;
        logic [2:0] pulse_mask;
    } lane_cfg_t;

    // Reset value of register idx; LEDs beyond the fourth reset to 0.
    function automatic logic [7:0] reg_reset_value(input int idx);
        case (idx)
            0:       return 8'hC5;
            1:       return 8'h67;
            2:       return 8'h70;
            3:       return 8'h03;
            4:       return 8'h20;
            6:       return 8'h40;
            8:       return 8'h40;
            9:       return 8'h20;
            default: return 8'h00;
        endcase
    endfunction

    // 4-bit per-LED condition decode; speed codes 1..7 are a mask of speeds.
    function automatic logic lane_cond(input logic [3:0] code, input link_state_t st);
        logic [2:0] speeds;
        speeds = {st.s1000, st.s100, st.s10} & {3{st.up}};
        case (code)
            4'h1, 4'h2, 4'h3, 4'h4,
            4'h5, 4'h6, 4'h7: return |(code[2:0] & speeds);
            4'h8:             return st.pdown;
            4'h9:             return st.eee;
            4'hA:             return st.aneg;
            4'hB:             return st.selftest;
            4'hC:             return st.cdiag;
            default:          return 1'b0;
        endcase
    endfunction

    // 3-bit decode used by the bank-wide scan and complex blink overrides.
    function automatic logic bank_cond(input logic [2:0] code, input link_state_t st);
        case (code)
            3'd1:    return st.up;
            3'd2:    return st.pdown;
            3'd3:    return st.eee;
            3'd4:    return st.aneg;
            3'd5:    return st.selftest;
            3'd6:    return st.cdiag;
            3'd7:    return st.test;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/led_ind_regs.sv
// Configuration register file for the LED controller.
// Stores 2 shared and 2 per-LED 8-bit registers; reads are combinational.
// Assumes one write per cycle; out-of-map accesses are ignored / read 0.
module led_ind_regs
    import led_ind_pkg::*;
#(
    parameter  int NUM_LEDS = 4,
    localparam int NREG     = 2 + 2 * NUM_LEDS,
    localparam int ADDR_W   = $clog2(NREG)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [7:0]                     wdata,
    output logic [7:0]                     rdata,
    output logic [1:0]                     fast_rate,
    output logic [1:0]                     slow_rate,
    output logic [2:0]                     scan_sel,
    output logic [2:0]                     cblink_sel,
    output lane_cfg_t [NUM_LEDS-1:0]       lane_cfg
);

    logic [NREG-1:0][7:0] regs_q;
    logic                 in_map;

    assign in_map = int'(addr) < NREG;

    // Register storage: reset load and single-port write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NREG; k++) begin
                regs_q[k] <= reg_reset_value(k);
            end
        end else if (wr && in_map) begin
            regs_q[addr] <= wdata;
        end
    end

    // Read mux: mapped registers, zero elsewhere.
    always_comb begin
        rdata = '0;
        if (in_map) begin
            rdata = regs_q[addr];
        end
    end

    // Shared field extraction.
    assign fast_rate  = regs_q[0][7:6];
    assign slow_rate  = regs_q[0][5:4];
    assign scan_sel   = regs_q[1][6:4];
    assign cblink_sel = regs_q[1][2:0];

    // Per-LED field extraction, one lane per LED.
    for (genvar i = 0; i < NUM_LEDS; i++) begin : g_lane_cfg
        assign lane_cfg[i] = {regs_q[2 + 2 * i], regs_q[3 + 2 * i][7:4], regs_q[3 + 2 * i][2:0]};
    end

endmodule

// File: rtl/led_ind_timebase.sv
// Shared blink timebase: divides the prescaler tick by TICK_DIV into a
// 4-bit phase counter; rate code c selects phase bit 3-c.
// Assumes tick is a single-cycle strobe.
module led_ind_timebase #(
    parameter  int TICK_DIV = 31,
    localparam int DIV_W    = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] fast_rate,
    input  logic [1:0] slow_rate,
    output logic [3:0] phase,
    output logic       fast_ph,
    output logic       slow_ph
);

    logic [DIV_W-1:0] div_q;

    // Tick divider and phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            phase <= '0;
        end else if (tick) begin
            if (div_q == DIV_W'(TICK_DIV - 1)) begin
                div_q <= '0;
                phase <= phase + 4'd1;
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    // Rate selection: higher code picks a faster phase bit.
    assign fast_ph = phase[2'd3 - fast_rate];
    assign slow_ph = phase[2'd3 - slow_rate];

endmodule

// File: rtl/led_ind_lane.sv
// One LED lane: activity stretch counter plus the priority mux
// override > activity blank > fast > slow > steady-on.
// Assumes tick is a single-cycle strobe; events are sampled each cycle.
module led_ind_lane
    import led_ind_pkg::*;
#(
    parameter  int STRETCH_TICKS = 30,
    localparam int SW            = $clog2(STRETCH_TICKS + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  lane_cfg_t   cfg,
    input  link_state_t st,
    input  logic        tx_act,
    input  logic        rx_act,
    input  logic        col_evt,
    input  logic        fast_ph,
    input  logic        slow_ph,
    input  logic        force_en,
    input  logic        force_val,
    output logic        led,
    output logic        busy,
    output logic        hit
);

    logic [SW-1:0] hold_q;

    assign hit  = |(cfg.pulse_mask & {col_evt, rx_act, tx_act});
    assign busy = hold_q != '0;

    // Activity stretch: reload on an event, count down on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (hit) begin
            hold_q <= SW'(STRETCH_TICKS);
        end else if (tick && busy) begin
            hold_q <= hold_q - 1'b1;
        end
    end

    // Output priority mux.
    always_comb begin
        if (force_en) begin
            led = force_val;
        end else if (busy) begin
            led = 1'b0;
        end else if (lane_cond(cfg.fast_sel, st)) begin
            led = fast_ph;
        end else if (lane_cond(cfg.slow_sel, st)) begin
            led = slow_ph;
        end else begin
            led = lane_cond(cfg.on_sel, st);
        end
    end

endmodule

// File: rtl/led_ind_ctrl.sv
// Top of the configurable link LED controller.
// Ties the register file, shared timebase and one lane per LED together,
// and applies the bank-wide scan and complex blink overrides.
// Assumes NUM_LEDS is a power of two between 2 and 16.
module led_ind_ctrl
    import led_ind_pkg::*;
#(
    parameter  int NUM_LEDS      = 4,
    parameter  int TICK_DIV      = 31,
    parameter  int STRETCH_TICKS = 30,
    localparam int NREG          = 2 + 2 * NUM_LEDS,
    localparam int ADDR_W        = $clog2(NREG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                cfg_wr,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [7:0]          cfg_wdata,
    output logic [7:0]          cfg_rdata,
    input  logic                link_up,
    input  logic [1:0]          link_speed,
    input  logic                pwr_down,
    input  logic                eee_active,
    input  logic                aneg_busy,
    input  logic                selftest_busy,
    input  logic                cdiag_busy,
    input  logic                test_mode,
    input  logic                tx_act,
    input  logic                rx_act,
    input  logic                col_evt,
    output logic [NUM_LEDS-1:0] led
);

    localparam int IDX_W = $clog2(NUM_LEDS);

    logic [1:0]               fast_rate;
    logic [1:0]               slow_rate;
    logic [2:0]               scan_sel;
    logic [2:0]               cblink_sel;
    lane_cfg_t [NUM_LEDS-1:0] lane_cfg;
    link_state_t              st;
    logic [3:0]               phase;
    logic                     fast_ph;
    logic                     slow_ph;
    logic                     scan_on;
    logic                     cblink_on;
    logic [NUM_LEDS-1:0]      force_val;
    logic [NUM_LEDS-1:0]      pulse_busy;
    logic [NUM_LEDS-1:0]      pulse_hit;

    // Status snapshot for the decoders.
    always_comb begin
        st.up       = link_up;
        st.s10      = link_speed == 2'd0;
        st.s100     = link_speed == 2'd1;
        st.s1000    = link_speed == 2'd2;
        st.pdown    = pwr_down;
        st.eee      = eee_active;
        st.aneg     = aneg_busy;
        st.selftest = selftest_busy;
        st.cdiag    = cdiag_busy;
        st.test     = test_mode;
    end

    led_ind_regs #(.NUM_LEDS(NUM_LEDS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (cfg_wr),
        .addr       (cfg_addr),
        .wdata      (cfg_wdata),
        .rdata      (cfg_rdata),
        .fast_rate  (fast_rate),
        .slow_rate  (slow_rate),
        .scan_sel   (scan_sel),
        .cblink_sel (cblink_sel),
        .lane_cfg   (lane_cfg)
    );

    led_ind_timebase #(.TICK_DIV(TICK_DIV)) u_timebase (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .fast_rate (fast_rate),
        .slow_rate (slow_rate),
        .phase     (phase),
        .fast_ph   (fast_ph),
        .slow_ph   (slow_ph)
    );

    // Bank-wide override conditions; scan outranks complex blink.
    assign scan_on   = bank_cond(scan_sel, st);
    assign cblink_on = bank_cond(cblink_sel, st);

    for (genvar i = 0; i < NUM_LEDS; i++) begin : g_lane
        // Override value: the scan position, or the slow phase for complex blink.
        assign force_val[i] = scan_on ? (phase[IDX_W-1:0] == IDX_W'(i)) : slow_ph;

        led_ind_lane #(.STRETCH_TICKS(STRETCH_TICKS)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .cfg       (lane_cfg[i]),
            .st        (st),
            .tx_act    (tx_act),
            .rx_act    (rx_act),
            .col_evt   (col_evt),
            .fast_ph   (fast_ph),
            .slow_ph   (slow_ph),
            .force_en  (scan_on | cblink_on),
            .force_val (force_val[i]),
            .led       (led[i]),
            .busy      (pulse_busy[i]),
            .hit       (pulse_hit[i])
        );
    end

endmodule

// File: rtl/led_ind_chk.sv
// Assertion checker for led_ind_ctrl, attached by bind below.
// Assumes the top's internal override and stretch signals by name.
module led_ind_chk #(
    parameter int NUM_LEDS = 4,
    parameter int NREG     = 10,
    parameter int ADDR_W   = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tick,
    input logic                cfg_wr,
    input logic [ADDR_W-1:0]   cfg_addr,
    input logic [7:0]          cfg_wdata,
    input logic [7:0]          cfg_rdata,
    input logic [NUM_LEDS-1:0] led,
    input logic [3:0]          phase,
    input logic                scan_on,
    input logic                cblink_on,
    input logic [NUM_LEDS-1:0] pulse_busy,
    input logic [NUM_LEDS-1:0] pulse_hit
);

    AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && int'(cfg_addr) < NREG) |=> (cfg_addr != $past(cfg_addr)) || (cfg_rdata == $past(cfg_wdata))); // R2

    AST_PHASE_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(phase)); // R6

    AST_SCAN_SINGLE_LIT: assert property (@(posedge clk) disable iff (!rst_n)
        scan_on |-> $countones(led) == 1); // R9

    AST_CBLINK_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
        (cblink_on && !scan_on) |-> (led == '0 || led == '1)); // R8

    for (genvar i = 0; i < NUM_LEDS; i++) begin : g_lane_chk
        AST_PULSE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
            pulse_hit[i] |=> pulse_busy[i]); // R7

        AST_PULSE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
            (pulse_busy[i] && !scan_on && !cblink_on) |-> !led[i]); // R7
    end

endmodule

bind led_ind_ctrl led_ind_chk #(
    .NUM_LEDS (NUM_LEDS),
    .NREG     (NREG),
    .ADDR_W   (ADDR_W)
) u_chk (.*);

// File: tb/test_led_ind_ctrl.sv
module test_led_ind_ctrl;

    localparam int N  = 4;
    localparam int TD = 2;
    localparam int ST = 3;
    localparam int NR = 2 + 2 * N;
    localparam int AW = $clog2(NR);

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [7:0]    cfg_wdata = '0;
    logic [7:0]    cfg_rdata;
    logic          link_up = 1'b0;
    logic [1:0]    link_speed = 2'd0;
    logic          pwr_down = 1'b0, eee_active = 1'b0, aneg_busy = 1'b0;
    logic          selftest_busy = 1'b0, cdiag_busy = 1'b0, test_mode = 1'b0;
    logic          tx_act = 1'b0, rx_act = 1'b0, col_evt = 1'b0;
    logic [N-1:0]  led;

    int checks = 0;
    int fails  = 0;

    logic [7:0] m_reg [NR];
    int         m_cnt = 0;
    logic [3:0] m_ph = '0;
    int         m_str [N];

    led_ind_ctrl #(.NUM_LEDS(N), .TICK_DIV(TD), .STRETCH_TICKS(ST)) i_led_ind_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .link_up(link_up), .link_speed(link_speed),
        .pwr_down(pwr_down), .eee_active(eee_active), .aneg_busy(aneg_busy),
        .selftest_busy(selftest_busy), .cdiag_busy(cdiag_busy), .test_mode(test_mode),
        .tx_act(tx_act), .rx_act(rx_act), .col_evt(col_evt), .led(led)
    );

    // R1 reset values as listed in the requirement.
    function automatic logic [7:0] rst_val(input int a);
        case (a)
            0: return 8'hC5; 1: return 8'h67; 2: return 8'h70; 3: return 8'h03;
            4: return 8'h20; 6: return 8'h40; 8: return 8'h40; 9: return 8'h20;
            default: return 8'h00;
        endcase
    endfunction

    // R3 condition table.
    function automatic bit want4(input logic [3:0] c);
        case (c)
            4'h1: return link_up && link_speed == 0;
            4'h2: return link_up && link_speed == 1;
            4'h3: return link_up && (link_speed == 0 || link_speed == 1);
            4'h4: return link_up && link_speed == 2;
            4'h5: return link_up && (link_speed == 0 || link_speed == 2);
            4'h6: return link_up && (link_speed == 1 || link_speed == 2);
            4'h7: return link_up && link_speed != 3;
            4'h8: return pwr_down;
            4'h9: return eee_active;
            4'hA: return aneg_busy;
            4'hB: return selftest_busy;
            4'hC: return cdiag_busy;
            default: return 1'b0;
        endcase
    endfunction

    // R10 bank condition table.
    function automatic bit want3(input logic [2:0] c);
        case (c)
            3'd1: return link_up;
            3'd2: return pwr_down;
            3'd3: return eee_active;
            3'd4: return aneg_busy;
            3'd5: return selftest_busy;
            3'd6: return cdiag_busy;
            3'd7: return test_mode;
            default: return 1'b0;
        endcase
    endfunction

    // Expected LED level from the model state and present inputs.
    function automatic bit exp_led(input int i, output string tag);
        logic [7:0] h;
        logic [7:0] l;
        bit fph;
        bit sph;
        h   = m_reg[2 + 2 * i];
        l   = m_reg[3 + 2 * i];
        fph = m_ph[3 - int'(m_reg[0][7:6])];
        sph = m_ph[3 - int'(m_reg[0][5:4])];
        if (want3(m_reg[1][6:4])) begin tag = "R9 R10"; return int'(m_ph[1:0]) == i; end
        if (want3(m_reg[1][2:0])) begin tag = "R8 R10"; return sph; end
        if (m_str[i] > 0)         begin tag = "R7";     return 1'b0; end
        if (want4(h[3:0]))        begin tag = "R4 R6";  return fph; end
        if (want4(l[7:4]))        begin tag = "R5 R6";  return sph; end
        tag = "R3";
        return want4(h[7:4]);
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Model advance for one rising edge, using the inputs that edge sampled.
    task automatic model_update();
        if (!rst_n) begin
            for (int a = 0; a < NR; a++) m_reg[a] = rst_val(a);
            m_cnt = 0;
            m_ph  = '0;
            for (int i = 0; i < N; i++) m_str[i] = 0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (|(m_reg[3 + 2 * i][2:0] & {col_evt, rx_act, tx_act})) m_str[i] = ST;
                else if (tick && m_str[i] > 0) m_str[i] = m_str[i] - 1;
            end
            if (tick) begin
                if (m_cnt == TD - 1) begin m_cnt = 0; m_ph = m_ph + 4'd1; end
                else m_cnt = m_cnt + 1;
            end
            if (cfg_wr && int'(cfg_addr) < NR) m_reg[cfg_addr] = cfg_wdata;
        end
    endtask

    // One clock: check at the falling edge, update the model after the rising edge.
    task automatic cycle();
        string tag;
        bit    e;
        @(negedge clk);
        #1;
        if (rst_n) begin
            for (int i = 0; i < N; i++) begin
                e = exp_led(i, tag);
                chk(tag, 8'(led[i]), 8'(e));
            end
            chk("R2", cfg_rdata, (int'(cfg_addr) < NR) ? m_reg[cfg_addr] : 8'h00);
        end
        @(posedge clk);
        model_update();
        #1;
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        cfg_wr    = 1'b1;
        cfg_addr  = AW'(a);
        cfg_wdata = d;
        cycle();
        cfg_wr    = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        int   toggles;
        logic prev;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < N; i++) m_str[i] = 0;
        repeat (3) cycle();
        rst_n = 1'b1;

        // R1: reset contents.
        for (int a = 0; a < NR; a++) begin
            cfg_addr = AW'(a);
            #1;
            chk("R1", cfg_rdata, rst_val(a));
            cycle();
        end

        // R2: unmapped write ignored and reads 0; mapped write reads back.
        wr(1, 8'h00);
        wr(12, 8'hFF);
        cfg_addr = AW'(12); #1; chk("R2", cfg_rdata, 8'h00);
        cfg_addr = AW'(0);  #1; chk("R2", cfg_rdata, 8'hC5);
        wr(7, 8'h5A);
        cfg_addr = AW'(7);  #1; chk("R2", cfg_rdata, 8'h5A);
        wr(7, 8'h00);

        // R3: every steady-on code on LED1 with the link up at 100.
        link_up = 1'b1; link_speed = 2'd1;
        for (int c = 0; c < 16; c++) begin
            wr(4, 8'(c << 4));
            #1;
            chk("R3", 8'(led[1]), 8'((c == 2 || c == 3 || c == 6 || c == 7) ? 1 : 0));
        end

        // R4 R6: fast at 16 Hz on LED0, slow at 2 Hz on LED3, link up at 1000.
        link_speed = 2'd2;
        wr(0, 8'hC0);
        wr(2, 8'h07); wr(3, 8'h00);
        wr(8, 8'h00); wr(9, 8'h70);
        tick = 1'b1;
        toggles = 0;
        prev = led[0];
        for (int t = 0; t < 16; t++) begin
            cycle();
            if (led[0] != prev) toggles++;
            prev = led[0];
        end
        chk("R6 fast toggles", 8'(toggles), 8'(16 / TD));
        toggles = 0;
        prev = led[3];
        for (int t = 0; t < 8 * TD; t++) begin
            cycle();
            if (led[3] != prev) toggles++;
            prev = led[3];
        end
        chk("R5 R6 slow toggles", 8'(toggles), 8'd1);
        tick = 1'b0;

        // R7: TX strobe blanks a steady LED for STRETCH_TICKS ticks.
        wr(2, 8'h70); wr(3, 8'h09);
        tx_act = 1'b1; cycle(); tx_act = 1'b0;
        chk("R7 blank", 8'(led[0]), 8'd0);
        repeat (5) cycle();
        chk("R7 hold without ticks", 8'(led[0]), 8'd0);
        tick = 1'b1;
        for (int t = 1; t <= ST; t++) begin
            cycle();
            chk("R7 stretch", 8'(led[0]), 8'((t == ST) ? 1 : 0));
        end
        tick = 1'b0;

        // R8 R10: complex blink on test mode.
        wr(1, 8'h07); test_mode = 1'b1;
        for (int t = 0; t < 4; t++) begin
            tick = 1'b1; cycle();
            chk("R8", 8'(led == '0 || led == '1), 8'd1);
        end
        test_mode = 1'b0;

        // R9 R10: scan on power-down, then on self-test.
        wr(1, 8'h20); pwr_down = 1'b1;
        for (int t = 0; t < 8; t++) begin
            cycle();
            chk("R9", 8'($countones(led)), 8'd1);
        end
        wr(1, 8'h50); selftest_busy = 1'b1;
        cycle();
        chk("R9 R10", 8'($countones(led)), 8'd1);
        selftest_busy = 1'b0; pwr_down = 1'b0; tick = 1'b0;

        // Constrained random traffic checked against the model each cycle.
        for (int k = 0; k < 4000; k++) begin
            tick          = ($urandom % 2) == 0;
            cfg_wr        = ($urandom % 12) == 0;
            cfg_addr      = AW'($urandom % 13);
            cfg_wdata     = 8'($urandom);
            if (cfg_addr == 1 && ($urandom % 4) != 0) cfg_wdata = 8'h00;
            link_up       = ($urandom % 4) != 0;
            link_speed    = 2'($urandom);
            pwr_down      = ($urandom % 6) == 0;
            eee_active    = ($urandom % 5) == 0;
            aneg_busy     = ($urandom % 5) == 0;
            selftest_busy = ($urandom % 7) == 0;
            cdiag_busy    = ($urandom % 7) == 0;
            test_mode     = ($urandom % 8) == 0;
            tx_act        = ($urandom % 10) == 0;
            rx_act        = ($urandom % 10) == 0;
            col_evt       = ($urandom % 20) == 0;
            rst_n         = ($urandom % 500) != 0;
            cycle();
        end
        cfg_wr = 1'b0;
        rst_n  = 1'b1;
        cycle();
        finish_run();
    end

endmodule